// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block performs the architectural bookkeeping of taking a trap on a processor with three privilege levels: machine, supervisor and user. A trap request carries a code, an interrupt flag, the address of the trapping instruction and a trap value. From the current privilege level and two delegation masks, the block picks the level whose handler runs. It then fills that level's cause, return-address and trap-value registers, stacks the interrupt-enable bits of the status word, switches the privilege level and redirects the program counter to that level's handler base.

The surrounding control-and-status file supplies the live privilege level, status word, delegation masks and vector bases. After each accepted trap, the block presents the committed privilege, status, per-level trap registers and the new PC, and pulses a redirect strobe. It also runs the architectural reset sequence. The trap request is a valid/ready stream. Ready is high whenever reset is low, so a request is accepted in any cycle in which valid is high and reset is low, and it never has to wait. All effects of one trap commit at the clock edge that accepts it.

Top module: `trap_entry_ctrl`

## Requirements
- R1: The handler level is machine (encoding 3) by default. It becomes supervisor (encoding 1) when the current level is not 3 and bit `trap_code` of `m_deleg_mask` is 1.
- R2: The handler level becomes user (encoding 0) when the current level is 0 and bit `trap_code` of `s_deleg_mask` is 1. This rule overrides R1 and does not depend on `m_deleg_mask`. From any other level the user handler is never chosen.
- R3: An accepted trap writes only the register bank of the handler level. The other two banks keep their values.
- R4: The written cause register equals `trap_code` zero-extended to XLEN bits, with `trap_irq` placed in bit XLEN-1.
- R5: The written return-address register takes `trap_pc`, and the written trap-value register takes `trap_tval`.
- R6: On a trap to user level, status bit 4 takes the old bit 0, and bit 0 is cleared.
- R7: On a trap to supervisor level, status bit 8 takes 1 if the previous level was supervisor and 0 if it was user. Bit 5 takes the old bit 1, and bit 1 is cleared.
- R8: On a trap to machine level, status bits 12:11 take the previous level, bit 7 takes the old bit 3, and bit 3 is cleared. On any trap, all status bits not named in R6 to R8 pass through from `status_i` unchanged.
- R9: One cycle after acceptance, `priv_o` shows the handler level, `pc_o` shows that level's vector base with bits 1:0 cleared, and `redirect_o` is high for exactly that cycle.
- R10: While `rst` is high, at each clock edge the block sets `priv_o` to 3, sets `status_o` to `status_i` with bits 3 and 17 cleared, zeroes all cause, return-address and trap-value registers, loads `pc_o` with the parameter RESET_PC and holds `redirect_o` low.
- R11: A trap request in the same cycle as reset has no effect. The reset values of R10 result.
- R12: `trap_ready` is low during reset and high otherwise. A cycle with `trap_valid` low leaves every output register unchanged, and `redirect_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_valid | input | 1 | Trap request valid |
| trap_ready | output | 1 | Trap request can be accepted |
| trap_code | input | $clog2(XLEN) | Exception or interrupt code |
| trap_irq | input | 1 | Request is an interrupt |
| trap_pc | input | XLEN | Address of the trapping instruction |
| trap_tval | input | XLEN | Trap value |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| status_i | input | XLEN | Current status word |
| m_deleg_mask | input | XLEN | Machine-level delegation mask, one bit per code |
| s_deleg_mask | input | XLEN | Supervisor-level delegation mask, one bit per code |
| m_vec_base | input | XLEN | Machine handler base |
| s_vec_base | input | XLEN | Supervisor handler base |
| u_vec_base | input | XLEN | User handler base |
| priv_o | output | 2 | Committed privilege level |
| status_o | output | XLEN | Committed status word |
| m_cause_o | output | XLEN | Machine cause register |
| m_ret_pc_o | output | XLEN | Machine return-address register |
| m_tval_o | output | XLEN | Machine trap-value register |
| s_cause_o | output | XLEN | Supervisor cause register |
| s_ret_pc_o | output | XLEN | Supervisor return-address register |
| s_tval_o | output | XLEN | Supervisor trap-value register |
| u_cause_o | output | XLEN | User cause register |
| u_ret_pc_o | output | XLEN | User return-address register |
| u_tval_o | output | XLEN | User trap-value register |
| pc_o | output | XLEN | Next program counter |
| redirect_o | output | 1 | One-cycle pulse when `pc_o` was loaded by a trap |

## Verification
Reset and trap acceptance can fall in the same cycle. The bench provokes this by raising `rst` while a fully populated trap request, aimed at the supervisor bank, is still valid. In the following cycle it expects the reset values throughout: machine level, cleared cause registers, RESET_PC and no redirect pulse. A behavioural model steps alongside the design and judges every cycle. Directed checks also confirm that the bank the trap would have written is still zero.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  // status word bit positions
  localparam int ST_UIE  = 0;
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_UPIE = 4;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;
  localparam int ST_MPRV = 17;

  localparam int NUM_LVL = 3;

  function automatic priv_e bank_level(input int idx);
    case (idx)
      0:       return PRIV_U;
      1:       return PRIV_S;
      default: return PRIV_M;
    endcase
  endfunction
endpackage

// File: rtl/trap_target_sel.sv
module trap_target_sel
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int CodeW = $clog2(XLEN)
) (
  input  logic [1:0]       cur_priv,
  input  logic [CodeW-1:0] code,
  input  logic [XLEN-1:0]  m_mask,
  input  logic [XLEN-1:0]  s_mask,
  output priv_e            target
);
  logic m_hit, s_hit;

  assign m_hit = m_mask[code];
  assign s_hit = s_mask[code];

  always_comb begin
    target = PRIV_M;
    if (cur_priv != PRIV_M && m_hit) target = PRIV_S;
    if (cur_priv == PRIV_U && s_hit) target = PRIV_U;
  end
endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur_status,
  input  logic [1:0]      prev_priv,
  input  priv_e           target,
  output logic [XLEN-1:0] next_status
);
  always_comb begin
    next_status = cur_status;
    case (target)
      PRIV_U: begin
        next_status[ST_UPIE] = cur_status[ST_UIE];
        next_status[ST_UIE]  = 1'b0;
      end
      PRIV_S: begin
        next_status[ST_SPP]  = (prev_priv != PRIV_U);
        next_status[ST_SPIE] = cur_status[ST_SIE];
        next_status[ST_SIE]  = 1'b0;
      end
      default: begin
        next_status[ST_MPP+1:ST_MPP] = prev_priv;
        next_status[ST_MPIE]         = cur_status[ST_MIE];
        next_status[ST_MIE]          = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [XLEN-1:0] cause_d,
  input  logic [XLEN-1:0] ret_pc_d,
  input  logic [XLEN-1:0] tval_d,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] ret_pc_q,
  output logic [XLEN-1:0] tval_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q  <= '0;
      ret_pc_q <= '0;
      tval_q   <= '0;
    end else if (we) begin
      cause_q  <= cause_d;
      ret_pc_q <= ret_pc_d;
      tval_q   <= tval_d;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000,
  localparam int CodeW = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trap_valid,
  output logic             trap_ready,
  input  logic [CodeW-1:0] trap_code,
  input  logic             trap_irq,
  input  logic [XLEN-1:0]  trap_pc,
  input  logic [XLEN-1:0]  trap_tval,
  input  logic [1:0]       priv_i,
  input  logic [XLEN-1:0]  status_i,
  input  logic [XLEN-1:0]  m_deleg_mask,
  input  logic [XLEN-1:0]  s_deleg_mask,
  input  logic [XLEN-1:0]  m_vec_base,
  input  logic [XLEN-1:0]  s_vec_base,
  input  logic [XLEN-1:0]  u_vec_base,
  output logic [1:0]       priv_o,
  output logic [XLEN-1:0]  status_o,
  output logic [XLEN-1:0]  m_cause_o,
  output logic [XLEN-1:0]  m_ret_pc_o,
  output logic [XLEN-1:0]  m_tval_o,
  output logic [XLEN-1:0]  s_cause_o,
  output logic [XLEN-1:0]  s_ret_pc_o,
  output logic [XLEN-1:0]  s_tval_o,
  output logic [XLEN-1:0]  u_cause_o,
  output logic [XLEN-1:0]  u_ret_pc_o,
  output logic [XLEN-1:0]  u_tval_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             redirect_o
);
  localparam logic [XLEN-1:0] RST_CLR = (XLEN'(1) << ST_MIE) | (XLEN'(1) << ST_MPRV);
  localparam logic [XLEN-1:0] VEC_MASK = ~XLEN'(3);

  priv_e           target;
  logic            fire;
  logic [XLEN-1:0] cause_w, stacked, vec_sel;
  logic [XLEN-1:0] cause_a [NUM_LVL];
  logic [XLEN-1:0] ret_a   [NUM_LVL];
  logic [XLEN-1:0] tval_a  [NUM_LVL];

  assign trap_ready = ~rst;
  assign fire       = trap_valid & trap_ready;
  assign cause_w    = {trap_irq, {(XLEN-1-CodeW){1'b0}}, trap_code};

  trap_target_sel #(.XLEN(XLEN)) u_sel (
    .cur_priv (priv_i),
    .code     (trap_code),
    .m_mask   (m_deleg_mask),
    .s_mask   (s_deleg_mask),
    .target   (target)
  );

  trap_status_stack #(.XLEN(XLEN)) u_stack (
    .cur_status  (status_i),
    .prev_priv   (priv_i),
    .target      (target),
    .next_status (stacked)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_bank
    localparam priv_e LVL = bank_level(g);
    trap_csr_bank #(.XLEN(XLEN)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .we       (fire && (target == LVL)),
      .cause_d  (cause_w),
      .ret_pc_d (trap_pc),
      .tval_d   (trap_tval),
      .cause_q  (cause_a[g]),
      .ret_pc_q (ret_a[g]),
      .tval_q   (tval_a[g])
    );
  end

  assign u_cause_o  = cause_a[0];
  assign u_ret_pc_o = ret_a[0];
  assign u_tval_o   = tval_a[0];
  assign s_cause_o  = cause_a[1];
  assign s_ret_pc_o = ret_a[1];
  assign s_tval_o   = tval_a[1];
  assign m_cause_o  = cause_a[2];
  assign m_ret_pc_o = ret_a[2];
  assign m_tval_o   = tval_a[2];

  always_comb begin
    case (target)
      PRIV_U:  vec_sel = u_vec_base;
      PRIV_S:  vec_sel = s_vec_base;
      default: vec_sel = m_vec_base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_o     <= PRIV_M;
      status_o   <= status_i & ~RST_CLR;
      pc_o       <= RESET_PC;
      redirect_o <= 1'b0;
    end else begin
      redirect_o <= fire;
      if (fire) begin
        priv_o   <= target;
        status_o <= stacked;
        pc_o     <= vec_sel & VEC_MASK;
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_valid,
  input logic            trap_irq,
  input logic [1:0]      priv_i,
  input logic [1:0]      priv_o,
  input logic [XLEN-1:0] status_o,
  input logic [XLEN-1:0] m_cause_o,
  input logic [XLEN-1:0] s_cause_o,
  input logic [XLEN-1:0] u_cause_o,
  input logic [XLEN-1:0] pc_o,
  input logic            redirect_o
);
  assert_idle_no_redirect_R12: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |=> !redirect_o);

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (priv_o == 2'd3) && (m_cause_o == '0) && !redirect_o);

  assert_pc_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (pc_o[1:0] == 2'b00));

  assert_other_banks_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && priv_i == 2'd3) |=> $stable(s_cause_o) && $stable(u_cause_o));

  assert_mie_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && priv_o == 2'd3) |-> !status_o[3]);

  assert_user_only_from_user_R2: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && priv_i != 2'd0) |=> (priv_o != 2'd0));

  assert_irq_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && priv_i == 2'd3) |=> (m_cause_o[XLEN-1] == $past(trap_irq)));
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_trap_entry_ctrl.sv
`timescale 1ns/1ps
module tb_trap_entry_ctrl;
  localparam int XL = 32;
  localparam logic [XL-1:0] RPC = 32'h0000_1000;

  logic clk = 0, rst = 1;
  logic trap_valid = 0, trap_ready, trap_irq = 0;
  logic [4:0] trap_code = 0;
  logic [XL-1:0] trap_pc = 0, trap_tval = 0, status_i = 0;
  logic [1:0] priv_i = 3;
  logic [XL-1:0] m_deleg_mask = 0, s_deleg_mask = 0;
  logic [XL-1:0] m_vec_base = 32'h8000_0103, s_vec_base = 32'h4000_0202, u_vec_base = 32'h2000_0301;
  logic [1:0] priv_o;
  logic [XL-1:0] status_o, pc_o;
  logic [XL-1:0] m_cause_o, m_ret_pc_o, m_tval_o, s_cause_o, s_ret_pc_o, s_tval_o;
  logic [XL-1:0] u_cause_o, u_ret_pc_o, u_tval_o;
  logic redirect_o;

  trap_entry_ctrl #(.XLEN(XL), .RESET_PC(RPC)) dut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0, cmp_on = 0;

  // behavioural reference state, indexed by privilege encoding
  logic [1:0] e_priv;
  logic [XL-1:0] e_status, e_pc;
  logic [XL-1:0] e_cause [4];
  logic [XL-1:0] e_ret [4];
  logic [XL-1:0] e_tval [4];
  logic e_redir;
  int last_tgt = 3;

  task automatic chk(string req, logic [XL-1:0] got, logic [XL-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int t;
    logic [XL-1:0] s;
    cycles++;
    if (rst) begin
      e_priv = 3;
      e_status = status_i & ~(32'h1 << 3) & ~(32'h1 << 17);
      for (int i = 0; i < 4; i++) begin e_cause[i] = 0; e_ret[i] = 0; e_tval[i] = 0; end
      e_pc = RPC;
      e_redir = 0;
    end else begin
      e_redir = trap_valid;
      if (trap_valid) begin
        t = 3;
        if (priv_i != 3 && m_deleg_mask[trap_code]) t = 1;
        if (priv_i == 0 && s_deleg_mask[trap_code]) t = 0;
        s = status_i;
        if (t == 0) begin s[4] = status_i[0]; s[0] = 0; end
        else if (t == 1) begin s[8] = (priv_i != 0); s[5] = status_i[1]; s[1] = 0; end
        else begin s[12:11] = priv_i; s[7] = status_i[3]; s[3] = 0; end
        e_status = s;
        e_cause[t] = (32'(trap_irq) << 31) | 32'(trap_code);
        e_ret[t] = trap_pc;
        e_tval[t] = trap_tval;
        e_priv = 2'(t);
        e_pc = (t == 0 ? u_vec_base : t == 1 ? s_vec_base : m_vec_base) & ~32'h3;
        last_tgt = t;
      end
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk("R9 priv", 32'(priv_o), 32'(e_priv));
    chk("R9 pc", pc_o, e_pc);
    chk("R9 redirect", 32'(redirect_o), 32'(e_redir));
    chk(last_tgt == 0 ? "R6 status" : last_tgt == 1 ? "R7 status" : "R8 status", status_o, e_status);
    chk("R4 m cause", m_cause_o, e_cause[3]);
    chk("R4 s cause", s_cause_o, e_cause[1]);
    chk("R4 u cause", u_cause_o, e_cause[0]);
    chk("R5 m ret", m_ret_pc_o, e_ret[3]);
    chk("R5 s ret", s_ret_pc_o, e_ret[1]);
    chk("R5 u ret", u_ret_pc_o, e_ret[0]);
    chk("R5 m tval", m_tval_o, e_tval[3]);
    chk("R5 s tval", s_tval_o, e_tval[1]);
    chk("R5 u tval", u_tval_o, e_tval[0]);
  end

  task automatic trap(input logic [1:0] p, input logic [4:0] c, input logic irq,
                      input logic [XL-1:0] st, input logic [XL-1:0] md, input logic [XL-1:0] sd);
    priv_i = p; trap_code = c; trap_irq = irq; status_i = st;
    m_deleg_mask = md; s_deleg_mask = sd;
    trap_pc = {8'hA0, 19'h0, c, 2'b00} ^ {30'(cycles), 2'b00};
    trap_tval = 32'hC0DE_0000 | 32'(cycles);
    trap_valid = 1;
    @(posedge clk);
    @(negedge clk);
    #1;
    trap_valid = 0;
  endtask

  initial begin
    logic [XL-1:0] saved;
    status_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    cmp_on = 1;
    #1;
    chk("R10 priv", 32'(priv_o), 32'd3);
    chk("R10 status", status_o, 32'hFFFD_FFF7);
    chk("R10 pc", pc_o, RPC);
    chk("R12 ready low in reset", 32'(trap_ready), 32'd0);
    rst = 0;
    @(negedge clk); #1;
    chk("R12 ready high", 32'(trap_ready), 32'd1);

    trap(2'd3, 5'd2, 0, 32'h0000_0088, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R1 from machine stays machine", 32'(priv_o), 32'd3);
    trap(2'd1, 5'd31, 1, 32'h0000_0002, 32'h8000_0000, 32'h0);
    chk("R1 supervisor delegation bit 31", 32'(priv_o), 32'd1);
    saved = m_cause_o;
    chk("R3 machine bank kept", m_cause_o, 32'h0000_0002);
    trap(2'd1, 5'd0, 0, 32'h0000_0002, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    chk("R1 mask bit clear keeps machine", 32'(priv_o), 32'd3);
    trap(2'd0, 5'd8, 0, 32'h0000_0001, 32'h0, 32'h0000_0100);
    chk("R2 user delegation", 32'(priv_o), 32'd0);
    chk("R6 upie", 32'(status_o[4]), 32'd1);
    trap(2'd0, 5'd9, 1, 32'h0000_0002, 32'h0000_0200, 32'h0);
    chk("R7 spp from user", 32'(status_o[8]), 32'd0);
    chk("R7 spie", 32'(status_o[5]), 32'd1);
    trap(2'd1, 5'd8, 0, 32'h0000_0001, 32'h0000_0100, 32'h0000_0100);
    chk("R2 user not chosen from supervisor", 32'(priv_o), 32'd1);
    chk("R7 spp from supervisor", 32'(status_o[8]), 32'd1);
    trap(2'd0, 5'd5, 0, 32'h0000_0008, 32'h0, 32'h0);
    chk("R8 mpp user", 32'(status_o[12:11]), 32'd0);
    chk("R8 mpie", 32'(status_o[7]), 32'd1);
    chk("R8 mie", 32'(status_o[3]), 32'd0);

    saved = pc_o;
    priv_i = 2'd1; status_i = 32'h5555_5555;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 idle keeps pc", pc_o, saved);
    chk("R12 idle no redirect", 32'(redirect_o), 32'd0);

    // reset and trap in the same cycle
    priv_i = 2'd1; trap_code = 5'd4; trap_irq = 1; m_deleg_mask = 32'hFFFF_FFFF;
    trap_pc = 32'h1234_5678; trap_tval = 32'h9ABC_DEF0; status_i = 32'h0002_000A;
    trap_valid = 1; rst = 1;
    @(posedge clk); @(negedge clk); #1;
    trap_valid = 0;
    chk("R11 priv", 32'(priv_o), 32'd3);
    chk("R11 s bank untouched", s_cause_o, 32'd0);
    chk("R11 pc", pc_o, RPC);
    chk("R11 no redirect", 32'(redirect_o), 32'd0);
    rst = 0;
    @(negedge clk);
    trap(2'd3, 5'd7, 1, 32'h0, 32'h0, 32'h0);
    chk("R4 irq cause", m_cause_o, 32'h8000_0007);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule